// File: doc/BRIEF.md
# Next Program Counter Unit

This block works out where a 32-bit RISC core fetches from next. Each cycle it takes the current program counter, the fetched instruction word and the two source register values. It decodes the control-transfer instructions, evaluates their condition and picks one of four targets. The targets are the sequential address, a PC-relative branch target, a pseudo-direct jump target built from the instruction's 26-bit index, and an address held in a register.

For the linking forms, the unit also presents the return address, the destination register number and a write enable for the register file. All results are registered once, so the core sees them one clock after it presents the inputs. Delay slots, prediction and flushing are handled elsewhere.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, `next_pc_o` becomes the parameter `RESET_PC` (default 0) and `link_we_o`, `link_idx_o` and `link_addr_o` become 0.
- R2: Every output reflects the inputs sampled at the previous rising edge and does not change between edges.
- R3: An instruction that is not a control transfer yields `next_pc_o = pc_i + 4`, which wraps modulo 2^32. This covers any opcode other than 0..7, opcode 0 with a function code other than 8 or 9, and opcode 1 with an rt field outside {0, 1, 16, 17}.
- R4: Opcode 4 branches when `rs_val_i == rt_val_i`, and opcode 5 branches when they differ. A taken branch goes to `pc_i + 4 + (sign-extended instr[15:0] << 2)`. An untaken one goes to `pc_i + 4`.
- R5: Opcode 6 branches when `rs_val_i` is at most zero, and opcode 7 when it is above zero. Both read the value as signed two's complement, ignore `rt_val_i`, and use the R4 target.
- R6: Opcode 1 selects its test from instr[20:16]: 0 branches when rs < 0, 1 when rs >= 0, 16 is the "< 0" test with link, and 17 is the ">= 0" test with link. All use the R4 target.
- R7: Opcodes 2 and 3 go to `{pc_i[31:28], instr[25:0], 2'b00}`. Opcode 3 also links.
- R8: Opcode 0 with function code instr[5:0] = 8 goes to `rs_val_i`. Function code 9 does the same and also links.
- R9: A linking instruction sets `link_we_o` = 1 and `link_addr_o = pc_i + 4`, whether or not its branch is taken. The destination `link_idx_o` is 31, except for function code 9, which uses instr[15:11]. Without a link, all three link outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_i | input | 32 | Address of the instruction being resolved |
| instr_i | input | 32 | Fetched instruction word |
| rs_val_i | input | 32 | Value of the register named by instr[25:21] |
| rt_val_i | input | 32 | Value of the register named by instr[20:16] |
| next_pc_o | output | 32 | Address to fetch next |
| link_we_o | output | 1 | Return-address write enable |
| link_idx_o | output | 5 | Register receiving the return address |
| link_addr_o | output | 32 | Return address |

## Verification
The assertions assume that `pc_i`, `instr_i` and both register values are driven to known levels on every edge where reset is released. They also assume that one edge of clean operation has passed before any `$past` comparison counts. The bench changes inputs only on falling edges, and it drives defined values from time zero through reset. As a result, every sampled input is settled and never X. The stimulus mixes directed corner cases (zero and sign-boundary operands, negative offsets, address wrap, region-top jumps, unknown sub-codes) with random words drawn mostly from the control opcodes.

// File: rtl/npc_pkg.sv
// Shared constants and types of the next-PC unit.
// Assumes a 32-bit word with the 6-bit major opcode in bits 31:26.
package npc_pkg;

    localparam int XLEN    = 32;
    localparam int OP_W    = 6;
    localparam int REG_W   = 5;
    localparam int IMM_W   = 16;
    localparam int IDX_W   = 26;
    localparam int REGION_W = XLEN - IDX_W - 2;

    localparam logic [OP_W-1:0] OP_SPECIAL = 6'd0;
    localparam logic [OP_W-1:0] OP_REGIMM  = 6'd1;
    localparam logic [OP_W-1:0] OP_JMP     = 6'd2;
    localparam logic [OP_W-1:0] OP_JMPLNK  = 6'd3;
    localparam logic [OP_W-1:0] OP_BREQ    = 6'd4;
    localparam logic [OP_W-1:0] OP_BRNE    = 6'd5;
    localparam logic [OP_W-1:0] OP_BRLEZ   = 6'd6;
    localparam logic [OP_W-1:0] OP_BRGTZ   = 6'd7;

    localparam logic [5:0] FN_REGJMP    = 6'd8;
    localparam logic [5:0] FN_REGJMPLNK = 6'd9;

    localparam logic [REG_W-1:0] SUB_LTZ    = 5'd0;
    localparam logic [REG_W-1:0] SUB_GEZ    = 5'd1;
    localparam logic [REG_W-1:0] SUB_LTZLNK = 5'd16;
    localparam logic [REG_W-1:0] SUB_GEZLNK = 5'd17;

    localparam logic [REG_W-1:0] RET_REG = 5'd31;

    typedef enum logic [3:0] {
        K_SEQ, K_EQ, K_NE, K_LEZ, K_GTZ, K_LTZ, K_GEZ, K_JUMP, K_JREG
    } ctl_kind_e;

    typedef struct packed {
        ctl_kind_e        kind;
        logic             link;
        logic [REG_W-1:0] link_idx;
    } npc_ctl_t;

endpackage

// File: rtl/npc_decode.sv
// Classifies an instruction into a control-transfer kind and link request.
// Assumes: only the opcode, rt, rd and function fields are needed here.
module npc_decode
    import npc_pkg::*;
(
    input  logic [OP_W-1:0]  op_i,
    input  logic [REG_W-1:0] rt_f_i,
    input  logic [REG_W-1:0] rd_f_i,
    input  logic [5:0]       fn_i,
    output npc_ctl_t         ctl_o
);

    // Map opcode and sub-fields onto a kind, a link flag and a destination.
    always_comb begin
        ctl_o = '{kind: K_SEQ, link: 1'b0, link_idx: '0};
        unique case (op_i)
            OP_SPECIAL: begin
                if (fn_i == FN_REGJMP) begin
                    ctl_o.kind = K_JREG;
                end else if (fn_i == FN_REGJMPLNK) begin
                    ctl_o.kind     = K_JREG;
                    ctl_o.link     = 1'b1;
                    ctl_o.link_idx = rd_f_i;
                end
            end
            OP_REGIMM: begin
                unique case (rt_f_i)
                    SUB_LTZ: ctl_o.kind = K_LTZ;
                    SUB_GEZ: ctl_o.kind = K_GEZ;
                    SUB_LTZLNK: begin
                        ctl_o.kind     = K_LTZ;
                        ctl_o.link     = 1'b1;
                        ctl_o.link_idx = RET_REG;
                    end
                    SUB_GEZLNK: begin
                        ctl_o.kind     = K_GEZ;
                        ctl_o.link     = 1'b1;
                        ctl_o.link_idx = RET_REG;
                    end
                    default: ctl_o.kind = K_SEQ;
                endcase
            end
            OP_JMP:    ctl_o.kind = K_JUMP;
            OP_JMPLNK: begin
                ctl_o.kind     = K_JUMP;
                ctl_o.link     = 1'b1;
                ctl_o.link_idx = RET_REG;
            end
            OP_BREQ:  ctl_o.kind = K_EQ;
            OP_BRNE:  ctl_o.kind = K_NE;
            OP_BRLEZ: ctl_o.kind = K_LEZ;
            OP_BRGTZ: ctl_o.kind = K_GTZ;
            default:  ctl_o.kind = K_SEQ;
        endcase
    end

endmodule

// File: rtl/npc_cond.sv
// Evaluates whether a control transfer is taken.
// Assumes register values are two's complement; unconditional kinds are taken.
module npc_cond
    import npc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  ctl_kind_e      kind_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic           taken_o
);

    logic a_neg;
    logic a_zero;
    logic a_eq_b;

    // Shared comparison terms.
    always_comb begin
        a_neg  = a_i[W-1];
        a_zero = (a_i == '0);
        a_eq_b = (a_i == b_i);
    end

    // Select the condition that belongs to the kind.
    always_comb begin
        unique case (kind_i)
            K_EQ:    taken_o = a_eq_b;
            K_NE:    taken_o = !a_eq_b;
            K_LEZ:   taken_o = a_neg || a_zero;
            K_GTZ:   taken_o = !a_neg && !a_zero;
            K_LTZ:   taken_o = a_neg;
            K_GEZ:   taken_o = !a_neg;
            K_JUMP,
            K_JREG:  taken_o = 1'b1;
            default: taken_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
// Forms the candidate targets and selects the next fetch address.
// Assumes XLEN = IDX_W + REGION_W + 2 so the pseudo-direct target fills a word.
module npc_target
    import npc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0]     pc_i,
    input  logic [IDX_W-1:0] field_i,
    input  logic [W-1:0]     reg_tgt_i,
    input  ctl_kind_e        kind_i,
    input  logic             taken_i,
    output logic [W-1:0]     seq_o,
    output logic [W-1:0]     next_o
);

    localparam int EXT_W = W - IMM_W - 2;

    logic [W-1:0] offset;
    logic [W-1:0] br_tgt;
    logic [W-1:0] jmp_tgt;

    // Sequential, relative and pseudo-direct candidates in parallel.
    always_comb begin
        seq_o   = pc_i + W'(4);
        offset  = {{EXT_W{field_i[IMM_W-1]}}, field_i[IMM_W-1:0], 2'b00};
        br_tgt  = seq_o + offset;
        jmp_tgt = {pc_i[W-1 -: REGION_W], field_i, 2'b00};
    end

    // Pick one candidate by kind and outcome.
    always_comb begin
        next_o = seq_o;
        if (taken_i) begin
            unique case (kind_i)
                K_JUMP:  next_o = jmp_tgt;
                K_JREG:  next_o = reg_tgt_i;
                K_SEQ:   next_o = seq_o;
                default: next_o = br_tgt;
            endcase
        end
    end

endmodule

// File: rtl/npc_unit.sv
// Next program counter unit: decode, condition, target, one output register.
// Assumes inputs are stable around each rising edge; reset is synchronous, active low.
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  instr_i,
    input  logic [XLEN-1:0]  rs_val_i,
    input  logic [XLEN-1:0]  rt_val_i,
    output logic [XLEN-1:0]  next_pc_o,
    output logic             link_we_o,
    output logic [REG_W-1:0] link_idx_o,
    output logic [XLEN-1:0]  link_addr_o
);

    npc_ctl_t        ctl;
    logic            taken;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] nxt_pc;
    logic            past_ok;

    npc_decode u_decode (
        .op_i   (instr_i[31:26]),
        .rt_f_i (instr_i[20:16]),
        .rd_f_i (instr_i[15:11]),
        .fn_i   (instr_i[5:0]),
        .ctl_o  (ctl)
    );

    npc_cond #(.W(XLEN)) u_cond (
        .kind_i  (ctl.kind),
        .a_i     (rs_val_i),
        .b_i     (rt_val_i),
        .taken_o (taken)
    );

    npc_target #(.W(XLEN)) u_target (
        .pc_i      (pc_i),
        .field_i   (instr_i[IDX_W-1:0]),
        .reg_tgt_i (rs_val_i),
        .kind_i    (ctl.kind),
        .taken_i   (taken),
        .seq_o     (seq_pc),
        .next_o    (nxt_pc)
    );

    // Output register: next address and link request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc_o   <= RESET_PC;
            link_we_o   <= 1'b0;
            link_idx_o  <= '0;
            link_addr_o <= '0;
        end else begin
            next_pc_o   <= nxt_pc;
            link_we_o   <= ctl.link;
            link_idx_o  <= ctl.link ? ctl.link_idx : '0;
            link_addr_o <= ctl.link ? seq_pc : '0;
        end
    end

    // Marks that the previous edge ran out of reset, so $past is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R9: a return address is always the word after the linking instruction.
    p_link_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && link_we_o) |-> (link_addr_o == $past(pc_i) + 32'd4));

    // R9: with no link request the link fields are quiet.
    p_link_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !link_we_o |-> (link_idx_o == '0 && link_addr_o == '0));

    // R3: a non-control instruction falls through.
    p_fallthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ctl.kind) == K_SEQ) |-> (next_pc_o == $past(pc_i) + 32'd4));

    // R7: a pseudo-direct jump stays in its region and is word aligned.
    p_jump_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(instr_i[31:26]) == OP_JMP)
        |-> (next_pc_o[31:28] == $past(pc_i[31:28]) && next_pc_o[1:0] == 2'b00));

    // R4: an equality branch on unequal operands falls through.
    p_eq_untaken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(instr_i[31:26]) == OP_BREQ && $past(rs_val_i != rt_val_i))
        |-> (next_pc_o == $past(pc_i) + 32'd4));

    // R8: a register jump lands on the register value.
    p_regjmp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(instr_i[31:26]) == OP_SPECIAL && $past(instr_i[5:0]) == FN_REGJMP)
        |-> (next_pc_o == $past(rs_val_i)));

endmodule

// File: tb/npc_unit_bench.sv
// Self-checking bench: a behavioural model predicts each output and is compared every vector.
module npc_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0;
    logic [31:0] instr_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [31:0] rt_val_i = '0;
    logic [31:0] next_pc_o;
    logic        link_we_o;
    logic [4:0]  link_idx_o;
    logic [31:0] link_addr_o;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] prev_pc = '0;

    always #10 clk = ~clk;

    npc_unit u_npc_unit (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .instr_i(instr_i),
        .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .next_pc_o(next_pc_o),
        .link_we_o(link_we_o), .link_idx_o(link_idx_o), .link_addr_o(link_addr_o)
    );

    function automatic logic [31:0] mk_i(int op, int rs, int rt, int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    function automatic logic [31:0] mk_j(int op, int idx);
        return {op[5:0], idx[25:0]};
    endfunction

    function automatic logic [31:0] mk_r(int rs, int rd, int fn);
        return {6'd0, rs[4:0], 5'd0, rd[4:0], 5'd0, fn[5:0]};
    endfunction

    // Behavioural expectation taken from the requirements.
    function automatic void model(input logic [31:0] pc, ins, a, b,
                                  output logic [31:0] npc, output logic we,
                                  output logic [4:0] ri, output logic [31:0] ra,
                                  output string tg);
        logic [31:0] seq;
        logic [31:0] tgt;
        int sa;
        seq = pc + 32'd4;
        tgt = seq + ({{16{ins[15]}}, ins[15:0]} << 2);
        sa  = $signed(a);
        npc = seq; we = 1'b0; ri = '0; ra = '0; tg = "R3";
        case (ins[31:26])
            6'd0: if (ins[5:0] == 6'd8 || ins[5:0] == 6'd9) begin
                tg = "R8"; npc = a;
                if (ins[5:0] == 6'd9) begin we = 1'b1; ri = ins[15:11]; ra = seq; end
            end
            6'd1: case (ins[20:16])
                5'd0:  begin tg = "R6"; if (sa < 0)  npc = tgt; end
                5'd1:  begin tg = "R6"; if (sa >= 0) npc = tgt; end
                5'd16: begin tg = "R6"; if (sa < 0)  npc = tgt; we = 1'b1; ri = 5'd31; ra = seq; end
                5'd17: begin tg = "R6"; if (sa >= 0) npc = tgt; we = 1'b1; ri = 5'd31; ra = seq; end
                default: tg = "R3";
            endcase
            6'd2, 6'd3: begin
                tg = "R7"; npc = {pc[31:28], ins[25:0], 2'b00};
                if (ins[26]) begin we = 1'b1; ri = 5'd31; ra = seq; end
            end
            6'd4: begin tg = "R4"; if (a == b) npc = tgt; end
            6'd5: begin tg = "R4"; if (a != b) npc = tgt; end
            6'd6: begin tg = "R5"; if (sa <= 0) npc = tgt; end
            6'd7: begin tg = "R5"; if (sa > 0)  npc = tgt; end
            default: tg = "R3";
        endcase
    endfunction

    task automatic check32(string tg, string what, logic [31:0] act, logic [31:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", tg, what, act, exp);
        end
    endtask

    // Drive one vector at a falling edge, check the hold (R2) and the result after the edge.
    task automatic apply(logic [31:0] pc, ins, a, b);
        logic [31:0] e_pc; logic e_we; logic [4:0] e_ri; logic [31:0] e_ra; string tg;
        model(pc, ins, a, b, e_pc, e_we, e_ri, e_ra, tg);
        pc_i = pc; instr_i = ins; rs_val_i = a; rt_val_i = b;
        #2;
        check32("R2", "hold before edge", next_pc_o, prev_pc);
        @(posedge clk);
        @(negedge clk);
        vectors++;
        check32(tg, "next_pc", next_pc_o, e_pc);
        check32("R9", "link_we", {31'd0, link_we_o}, {31'd0, e_we});
        check32("R9", "link_idx", {27'd0, link_idx_o}, {27'd0, e_ri});
        check32("R9", "link_addr", link_addr_o, e_ra);
        prev_pc = e_pc;
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        pc_i = 32'h1234_5670; instr_i = mk_j(2, 5);
        repeat (3) @(negedge clk);
        // R1: reset state
        vectors++;
        check32("R1", "reset next_pc", next_pc_o, 32'h0);
        check32("R1", "reset link_we", {31'd0, link_we_o}, 32'd0);
        check32("R1", "reset link_idx", {27'd0, link_idx_o}, 32'd0);
        check32("R1", "reset link_addr", link_addr_o, 32'd0);
        rst_n = 1'b1;
        prev_pc = 32'h0;

        // R3: fall-through, unknown function code, unknown sub-code, wrap
        apply(32'h0000_1000, 32'h0232_4021, 32'd3, 32'd3);
        apply(32'h0000_2000, mk_i(6'h23, 1, 2, 8), 32'd0, 32'd0);
        apply(32'hFFFF_FFFC, mk_r(4, 3, 6'h21), 32'd9, 32'd9);
        apply(32'h0000_3000, mk_i(1, 4, 5, 16'h0010), 32'hFFFF_FFFF, 32'd0);
        // R4: equality pair
        apply(32'h0001_0000, mk_i(4, 1, 2, 16'h0002), 32'd7, 32'd7);
        apply(32'h0001_0000, mk_i(4, 1, 2, 16'h0002), 32'd7, 32'd8);
        apply(32'h0001_0000, mk_i(5, 1, 2, 16'hFFFE), 32'd1, 32'd2);
        apply(32'h0001_0000, mk_i(5, 1, 2, 16'h8000), 32'd5, 32'd5);
        apply(32'h0000_0000, mk_i(5, 1, 2, 16'hFFFF), 32'd0, 32'd1);
        // R5: signed compare with zero, rt ignored
        apply(32'h0002_0000, mk_i(6, 1, 9, 16'h0004), 32'd0, 32'hFFFF_FFFF);
        apply(32'h0002_0000, mk_i(6, 1, 9, 16'h0004), 32'h8000_0000, 32'd0);
        apply(32'h0002_0000, mk_i(6, 1, 9, 16'h0004), 32'd1, 32'd0);
        apply(32'h0002_0000, mk_i(7, 1, 9, 16'h7FFF), 32'h8000_0000, 32'd1);
        apply(32'h0002_0000, mk_i(7, 1, 9, 16'h7FFF), 32'd1, 32'd1);
        apply(32'h0002_0000, mk_i(7, 1, 9, 16'h7FFF), 32'd0, 32'd1);
        // R6: single-register tests selected by rt field
        apply(32'h0003_0000, mk_i(1, 1, 0, 16'h0003), 32'hFFFF_FFFF, 32'd0);
        apply(32'h0003_0000, mk_i(1, 1, 0, 16'h0003), 32'd0, 32'd0);
        apply(32'h0003_0000, mk_i(1, 1, 1, 16'hFFF0), 32'd0, 32'd0);
        apply(32'h0003_0000, mk_i(1, 1, 1, 16'hFFF0), 32'h8000_0000, 32'd0);
        // R9: linked single-register branches link even when not taken
        apply(32'h0003_0000, mk_i(1, 1, 16, 16'h0008), 32'd5, 32'd0);
        apply(32'h0003_0000, mk_i(1, 1, 17, 16'h0008), 32'd5, 32'd0);
        // R7: pseudo-direct jumps, region top
        apply(32'hA000_0000, mk_j(2, 26'h3FF_FFFF), 32'd0, 32'd0);
        apply(32'h5FFF_FFF0, mk_j(3, 26'h000_0001), 32'd0, 32'd0);
        // R8: register jumps, linked with chosen destination
        apply(32'h0004_0000, mk_r(7, 0, 8), 32'h1234_5678, 32'd0);
        apply(32'h0004_0000, mk_r(7, 7, 9), 32'hDEAD_BEE0, 32'd0);
        apply(32'h0004_0000, mk_r(7, 0, 9), 32'h0000_0100, 32'd0);

        // Mixed random vectors biased toward control opcodes.
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] w; logic [31:0] a; logic [31:0] b;
            w = $urandom;
            case ($urandom_range(0, 9))
                0, 1, 2, 3, 4, 5, 6, 7: w[31:26] = 6'($urandom_range(0, 7));
                default: ;
            endcase
            if (w[31:26] == 6'd0 && $urandom_range(0, 2) != 0) w[5:0] = 6'($urandom_range(8, 9));
            if (w[31:26] == 6'd1 && $urandom_range(0, 3) != 0) w[20:16] = ($urandom_range(0, 1) != 0) ? 5'd16 : 5'd0;
            if (w[31:26] == 6'd1 && $urandom_range(0, 1) != 0) w[16] = 1'b1;
            a = $urandom;
            b = ($urandom_range(0, 2) == 0) ? a : 32'($urandom);
            if ($urandom_range(0, 5) == 0) a = 32'd0;
            apply(32'($urandom), w, a, b);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule